// File: doc/BRIEF.md
# Vertical Blanking Line Decoder

This block keeps a frame line counter and decodes its value into a vertical blanking flag. The counter advances by one for each start-of-line pulse and wraps to zero at the end of a frame. Two single-value match terms watch the counter. One sets a small state bit and the other clears it, so blanking stays asserted for the lines between the two terms. No magnitude comparison is involved.

Each match term is built the way a wired-NOR decoder is. Every counter bit, and the interlace mode bit, is offered to the term on a true rail and on an inverted rail. A rail joins a pull-down list when it would show a mismatch, and the term fires when no rail in its list is high. The counter's lowest bit and the interlace bit are in no list. Blanking therefore depends only on the upper nine counter bits. The same nine bits, with bit 0 dropped, are also presented as the raster line number that a status read would return.

Top module: `vblank_decoder`

## Requirements
- R1: After reset, and before any line pulse, `vcount` is 0, `raster_line` is 0 and `vblank` is 0.
- R2: `vcount` increases by exactly one on each clock edge at which `line_adv` is high. On every other edge it keeps its value.
- R3: With `line_adv` high and `vcount` equal to FRAME_LINES-1 (311 by default), the next value of `vcount` is 0.
- R4: `raster_line` always equals `vcount` shifted right by one place. Bit 0 of the counter is dropped.
- R5: When `vcount` holds 2 or 3 (upper nine bits equal 1) at a clock edge, `vblank` reads 1 after that edge. Bit 0 of the counter makes no difference to this.
- R6: Once set, `vblank` stays 1 for every counter value up to and including 19.
- R7: When `vcount` holds 20 or 21 (upper nine bits equal 10) at a clock edge, `vblank` reads 0 after that edge. It stays 0 until the set value comes round again.
- R8: The counter values 0 and 1 at the start of each frame never cause blanking. `vblank` is 0 after edges at which `vcount` is 0 or 1.
- R9: The `interlace` input has no effect on `vblank`, `vcount` or `raster_line`, whether it is held at either level or toggled on every cycle.
- R10: `vblank` changes one clock after the counter reaches a matching value. The state bit is updated on every clock edge from the current counter value, whether or not `line_adv` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_adv | input | 1 | Start-of-line enable; advances the line counter |
| interlace | input | 1 | Interlace mode bit, offered to the decoder rails |
| vcount | output | 10 | Current line counter value |
| raster_line | output | 9 | Counter with bit 0 dropped, as seen by a status read |
| vblank | output | 1 | Registered vertical blanking flag |

## Verification
The assertions are written against the block's internally synchronised reset. They assume that `line_adv` and `interlace` are steady around each rising edge, and that the counter starts from its reset value, so it never holds a value at or beyond the frame length. The stimulus changes both inputs only on the falling clock edge, and it never forces the counter. It applies `interlace` held low, held high, and toggling on every cycle. It also mixes continuous line pulses with pulses spaced three cycles apart. The spaced pulses make the counter rest on each value, including 2, 3, 20 and 21, for several edges.

// File: rtl/vbd_pkg.sv
package vbd_pkg;

  // Action chosen for the blanking state bit on the next edge.
  typedef enum logic [1:0] {
    BLK_HOLD  = 2'd0,
    BLK_SET   = 2'd1,
    BLK_CLEAR = 2'd2
  } blk_action_e;

endpackage

// File: rtl/vbd_rst_sync.sv
module vbd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // A one is shifted in from the bottom. Reset is asserted at once and
  // released only after STAGES edges.
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/vbd_line_counter.sv
module vbd_line_counter #(
  parameter int CNT_W       = 10,
  parameter int FRAME_LINES = 312
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(FRAME_LINES - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             at_last;

  always_comb begin
    at_last = (count_q == LAST_VAL);
    count_d = count_q;
    if (adv) begin
      if (at_last) begin
        count_d = '0;
      end else begin
        count_d = count_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/vbd_match_term.sv
module vbd_match_term #(
  parameter int CNT_W       = 10,
  parameter int MATCH_UPPER = 1
) (
  input  logic [2*(CNT_W+1)-1:0] rails,
  output logic                   hit
);

  localparam int RAIL_W   = 2 * (CNT_W + 1);
  localparam int INV_BASE = CNT_W + 1;

  // Rail layout: [CNT_W:0] carries the true counter bits and then the
  // interlace bit; [2*CNT_W+1:CNT_W+1] carries their inverses.
  // A rail joins the pull-down list when being high means a mismatch.
  // Counter bit 0 and the interlace bit are never in the list.
  function automatic logic [RAIL_W-1:0] pulldown_map();
    logic [RAIL_W-1:0] m;
    m = '0;
    for (int i = 1; i < CNT_W; i++) begin
      if (((MATCH_UPPER >> (i - 1)) & 1) != 0) begin
        m[INV_BASE + i] = 1'b1;
      end else begin
        m[i] = 1'b1;
      end
    end
    return m;
  endfunction

  localparam logic [RAIL_W-1:0] PD_MAP = pulldown_map();

  logic [RAIL_W-1:0] pull;

  always_comb begin
    pull = rails & PD_MAP;
    hit  = ~|pull;
  end

endmodule

// File: rtl/vbd_sr_latch.sv
module vbd_sr_latch
  import vbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_hit,
  input  logic clr_hit,
  output logic q
);

  blk_action_e act;
  logic        q_q;
  logic        q_d;

  // Clear beats set if both terms ever fire on the same edge.
  always_comb begin
    if (clr_hit) begin
      act = BLK_CLEAR;
    end else if (set_hit) begin
      act = BLK_SET;
    end else begin
      act = BLK_HOLD;
    end
  end

  always_comb begin
    unique case (act)
      BLK_SET:   q_d = 1'b1;
      BLK_CLEAR: q_d = 1'b0;
      default:   q_d = q_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= 1'b0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q = q_q;

endmodule

// File: rtl/vblank_decoder.sv
module vblank_decoder #(
  parameter int CNT_W       = 10,
  parameter int FRAME_LINES = 312,
  parameter int SET_ROW     = 1,
  parameter int CLEAR_ROW   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_adv,
  input  logic             interlace,
  output logic [CNT_W-1:0] vcount,
  output logic [CNT_W-2:0] raster_line,
  output logic             vblank
);

  localparam int SENSE_W = CNT_W + 1;
  localparam int RAIL_W  = 2 * SENSE_W;

  logic               rst_int_n;
  logic [SENSE_W-1:0] sense;
  logic [RAIL_W-1:0]  rails;
  logic               set_hit;
  logic               clr_hit;

  vbd_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  vbd_line_counter #(
    .CNT_W       (CNT_W),
    .FRAME_LINES (FRAME_LINES)
  ) u_counter (
    .clk   (clk),
    .rst_n (rst_int_n),
    .adv   (line_adv),
    .count (vcount)
  );

  assign sense = {interlace, vcount};

  // Each sensed bit is offered to the decoder on a true rail and an
  // inverted rail.
  for (genvar b = 0; b < SENSE_W; b++) begin : g_rail
    assign rails[b]           = sense[b];
    assign rails[SENSE_W + b] = ~sense[b];
  end

  vbd_match_term #(
    .CNT_W       (CNT_W),
    .MATCH_UPPER (SET_ROW)
  ) u_set_term (
    .rails (rails),
    .hit   (set_hit)
  );

  vbd_match_term #(
    .CNT_W       (CNT_W),
    .MATCH_UPPER (CLEAR_ROW)
  ) u_clr_term (
    .rails (rails),
    .hit   (clr_hit)
  );

  vbd_sr_latch u_blank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_hit (set_hit),
    .clr_hit (clr_hit),
    .q       (vblank)
  );

  assign raster_line = vcount[CNT_W-1:1];

endmodule

// File: rtl/vbd_checker.sv
module vbd_checker #(
  parameter int CNT_W       = 10,
  parameter int FRAME_LINES = 312,
  parameter int SET_ROW     = 1,
  parameter int CLEAR_ROW   = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_adv,
  input logic [CNT_W-1:0] vcount,
  input logic             vblank
);

  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(FRAME_LINES - 1);
  localparam logic [CNT_W-2:0] SET_U    = (CNT_W-1)'(SET_ROW);
  localparam logic [CNT_W-2:0] CLR_U    = (CNT_W-1)'(CLEAR_ROW);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_adv |=> $stable(vcount));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_adv && vcount == LAST_VAL) |=> (vcount == '0));

  assert_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vcount <= LAST_VAL);

  assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vcount[CNT_W-1:1] == SET_U) |=> vblank);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vcount[CNT_W-1:1] == CLR_U) |=> !vblank);

  assert_rise_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> ($past(vcount[CNT_W-1:1]) == SET_U));

  assert_fall_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vblank) |-> ($past(vcount[CNT_W-1:1]) == CLR_U));

endmodule

bind vblank_decoder vbd_checker #(
  .CNT_W       (CNT_W),
  .FRAME_LINES (FRAME_LINES),
  .SET_ROW     (SET_ROW),
  .CLEAR_ROW   (CLEAR_ROW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .line_adv (line_adv),
  .vcount   (vcount),
  .vblank   (vblank)
);

// File: tb/vblank_decoder_test.sv
`timescale 1ns/1ps
module vblank_decoder_test;

  localparam int    FRAME = 312;
  localparam real   HALF  = 2.0;
  localparam int    LIMIT = 200000;

  logic       clk;
  logic       rst_n;
  logic       line_adv;
  logic       interlace;
  logic [9:0] vcount;
  logic [8:0] raster_line;
  logic       vblank;

  int checks;
  int fails;
  int exp_cnt;
  bit exp_vb;
  int cycles;

  vblank_decoder uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_adv    (line_adv),
    .interlace   (interlace),
    .vcount      (vcount),
    .raster_line (raster_line),
    .vblank      (vblank)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  // One clock: drive on the falling edge, sample 1 ns after the rising edge.
  task automatic step(input bit adv, input bit il, input string phase);
    int    old;
    string vtag;
    @(negedge clk);
    line_adv  = adv;
    interlace = il;
    @(posedge clk);
    #1;
    cycles++;
    old = exp_cnt;
    // The blanking bit follows the counter value held at this edge.
    if ((old >> 1) == 10) begin
      exp_vb = 1'b0;
      vtag = "R7";
    end else if ((old >> 1) == 1) begin
      exp_vb = 1'b1;
      vtag = "R5";
    end else if (old < 2) begin
      vtag = "R8";
    end else if (exp_vb) begin
      vtag = "R6";
    end else begin
      vtag = "R10";
    end
    if (adv) begin
      exp_cnt = (old == FRAME - 1) ? 0 : old + 1;
    end
    check(vcount == 10'(exp_cnt),
          (adv && old == FRAME - 1) ? {"R3 ", phase} : {"R2 ", phase},
          int'(vcount), exp_cnt);
    check(raster_line == 9'(exp_cnt >> 1), {"R4 ", phase}, int'(raster_line), exp_cnt >> 1);
    check(vblank == exp_vb, {vtag, " ", phase}, int'(vblank), int'(exp_vb));
  endtask

  initial begin
    #(LIMIT * 2.0 * HALF);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", LIMIT, cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks    = 0;
    fails     = 0;
    cycles    = 0;
    exp_cnt   = 0;
    exp_vb    = 1'b0;
    line_adv  = 1'b0;
    interlace = 1'b0;
    rst_n     = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: the state after reset, before any line pulse
    #0.5;
    check(vcount == 10'd0, "R1 count", int'(vcount), 0);
    check(raster_line == 9'd0, "R1 raster", int'(raster_line), 0);
    check(vblank == 1'b0, "R1 blank", int'(vblank), 0);

    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "idle");

    // Continuous line pulses, interlace low: R5 R6 R7 R8 R10
    for (int k = 0; k < FRAME + 30; k++) step(1'b1, 1'b0, "il0");
    // Interlace held high: R9
    for (int k = 0; k < FRAME; k++) step(1'b1, 1'b1, "R9 il1");
    // Interlace toggling every cycle: R9
    for (int k = 0; k < FRAME; k++) step(1'b1, k[0], "R9 iltog");
    // Spaced pulses: counter rests on every value, including 2, 3, 20, 21
    for (int k = 0; k < FRAME + 25; k++) begin
      step(1'b1, 1'b0, "spaced");
      step(1'b0, k[1], "R9 rest");
      step(1'b0, 1'b0, "rest");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule